// File: doc/BRIEF.md
# Interrupt Controller with Acknowledge

This block gathers up to fifteen interrupt source lines from peripherals such as a timer, a serial receiver, a serial transmitter and a keypad. Each source is sampled on every clock and caught in a latch of pending bits. A per-source enable mask and a global enable gate the pending bits into a single interrupt request line to the CPU. Priority, vectoring and nesting are handled elsewhere.

The CPU sees the controller as one 32-bit register at word address 0x0400 on the peripheral bus. A read returns the global enable, the enable mask, a summary flag and the pending bits. A write acknowledges pending sources and updates the enables. Every write to the register also sets or clears the global enable. A source whose condition is still present latches again on the next clock, so acknowledging it does not clear it. The bus side is a plain one-cycle write strobe with an always-valid read word. No stream handshake is used, so there is no back-pressure.

Top module: `intc_ack`

## Requirements
- R1: After reset, the read word is all zero and `cpu_irq` is low.
- R2: A source line that is high at a rising clock edge sets its pending bit (read bits 14:0, bit i for source i). The bit stays set after the line drops.
- R3: A register write with a 1 in position i of bits 14:0 clears pending bit i. A 0 in that position leaves the bit unchanged.
- R4: Every register write loads the global enable (read bit 31) from bit 31 of the written word.
- R5: The enable mask (read bits 30:16, bit 16+i for source i) is loaded from bits 30:16 of the written word only when bit 15 of that word is 1. When bit 15 is 0, the mask keeps its value.
- R6: `cpu_irq` is high exactly when the global enable is set and at least one pending bit has its enable set.
- R7: If a source is high in the same cycle that its pending bit is acknowledged, the bit stays set. A persistent source therefore cannot be cleared.
- R8: Read bit 15 is 1 whenever any pending bit is set, whatever the enables.
- R9: A write strobe whose address is not 0x0400 changes none of the controller's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 16 | Word address of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Register contents {global enable, enables, any-pending, pending} |
| irq_src | input | 15 | Interrupt source lines |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench acknowledges a source while its line is still high. A design that let the clear win would drop a pending receive interrupt and lose data. It writes a word with bit 15 low and checks that the enables survive, which catches a design that always loads the mask. It also checks that an acknowledge-only write with bit 31 low turns interrupts off, which catches a design that updates the global enable only on enable writes. Finally, it writes to a neighbouring address and expects no change, which exposes an incomplete address decode.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int MAX_SRC  = 15;
  localparam int GIE_BIT  = 31;
  localparam int EN_LSB   = 16;
  localparam int ANY_BIT  = 15;
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int NSRC = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] ack_mask,
  output logic [NSRC-1:0] pending
);
  // a new arrival overrides an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~ack_mask) | src;
  end

  AST_ARRIVAL_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (src != '0) |=> ((pending & $past(src)) == $past(src))); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & ~$past(pending) & ~$past(src)) == '0)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask != '0) |=> ((pending & $past(ack_mask & ~src)) == '0)); // R3
endmodule

// File: rtl/intc_enable.sv
module intc_enable #(
  parameter int NSRC = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            gie_in,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_in,
  output logic [NSRC-1:0] en,
  output logic            gie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= '0;
      gie <= 1'b0;
    end else if (wr) begin
      gie <= gie_in;
      if (en_wr) en <= en_in;
    end
  end

  AST_GIE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (gie == $past(gie_in))); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && en_wr) |=> $stable(en)); // R5
endmodule

// File: rtl/intc_ack.sv
module intc_ack
  import intc_pkg::*;
#(
  parameter int          NSRC     = 15,
  parameter int          AW       = 16,
  parameter logic [15:0] REG_ADDR = 16'h0400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NSRC-1:0] irq_src,
  output logic          cpu_irq
);
  localparam int PAD = MAX_SRC - NSRC;

  logic            reg_wr;
  logic [NSRC-1:0] ack_mask;
  logic [NSRC-1:0] pending;
  logic [NSRC-1:0] en;
  logic            gie;
  logic [MAX_SRC-1:0] pend_w;
  logic [MAX_SRC-1:0] en_w;

  assign reg_wr   = bus_wr && (bus_addr == REG_ADDR[AW-1:0]);
  assign ack_mask = reg_wr ? bus_wdata[NSRC-1:0] : '0;

  intc_pending #(.NSRC(NSRC)) i_pending (
    .clk(clk), .rst_n(rst_n), .src(irq_src),
    .ack_mask(ack_mask), .pending(pending)
  );

  intc_enable #(.NSRC(NSRC)) i_enable (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr),
    .gie_in(bus_wdata[GIE_BIT]), .en_wr(bus_wdata[ANY_BIT]),
    .en_in(bus_wdata[EN_LSB +: NSRC]), .en(en), .gie(gie)
  );

  generate
    if (PAD > 0) begin : g_pad
      assign pend_w = {{PAD{1'b0}}, pending};
      assign en_w   = {{PAD{1'b0}}, en};
    end else begin : g_full
      assign pend_w = pending;
      assign en_w   = en;
    end
  endgenerate

  assign bus_rdata = {gie, en_w, |pend_w, pend_w};
  assign cpu_irq   = gie && ((pending & en) != '0);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (bus_rdata[GIE_BIT] && bus_rdata[ANY_BIT])); // R6
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !reg_wr && irq_src == '0) |=> $stable(bus_rdata)); // R9
endmodule

// File: tb/test_intc_ack.sv
module test_intc_ack;
  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [14:0] src;
    logic [31:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0400, 32'h0000_0000, 15'h0000, 32'h0000_0000, 1'b0}, // R1
    '{1'b0, 16'h0400, 32'h0000_0000, 15'h0001, 32'h0000_8001, 1'b0}, // R2 R8
    '{1'b0, 16'h0400, 32'h0000_0000, 15'h0000, 32'h0000_8001, 1'b0}, // R2 latch
    '{1'b1, 16'h0400, 32'h8003_8000, 15'h0000, 32'h8003_8001, 1'b1}, // R5 R6
    '{1'b1, 16'h0400, 32'h8000_0001, 15'h0000, 32'h8003_0000, 1'b0}, // R3 R5
    '{1'b0, 16'h0400, 32'h0000_0000, 15'h0004, 32'h8003_8004, 1'b0}, // R6 masked
    '{1'b1, 16'h0400, 32'h0000_0000, 15'h0000, 32'h0003_8004, 1'b0}, // R4 R3
    '{1'b0, 16'h0400, 32'h0000_0000, 15'h0002, 32'h0003_8006, 1'b0}, // R6 gie off
    '{1'b1, 16'h0400, 32'h8000_0000, 15'h0000, 32'h8003_8006, 1'b1}, // R4
    '{1'b1, 16'h0404, 32'h0000_FFFF, 15'h0000, 32'h8003_8006, 1'b1}, // R9
    '{1'b1, 16'h0400, 32'h8000_0002, 15'h0002, 32'h8003_8006, 1'b1}, // R7
    '{1'b1, 16'h0400, 32'h8000_0006, 15'h0000, 32'h8003_0000, 1'b0}, // R3
    '{1'b1, 16'h0400, 32'h0000_8000, 15'h0000, 32'h0000_0000, 1'b0}, // R5 R4
    '{1'b0, 16'h0400, 32'h0000_0000, 15'h4000, 32'h0000_C000, 1'b0}, // R2 top bit
    '{1'b1, 16'h0400, 32'hC000_8000, 15'h0000, 32'hC000_C000, 1'b1}  // R6 top bit
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [14:0] irq_src = '0;
  logic        cpu_irq;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  intc_ack i_intc_ack (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] rd, input logic irq);
    checks++;
    if (bus_rdata !== rd || cpu_irq !== irq) begin
      fails++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
               req, bus_rdata, cpu_irq, rd, irq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_wr    = VEC[i].wr;
      bus_addr  = VEC[i].addr;
      bus_wdata = VEC[i].wd;
      irq_src   = VEC[i].src;
      @(negedge clk);
      bus_wr  = 1'b0;
      irq_src = '0;
      check($sformatf("vector %0d", i), VEC[i].exp_rd, VEC[i].exp_irq);
    end
    // R5: write with bit 15 low keeps the mask, R4 still loads gie
    bus_wr = 1'b1; bus_addr = 16'h0400; bus_wdata = 32'h3FFF_0000;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R5 mask held", 32'h4000_C000, 1'b0);
    // R7: persistent source through two acknowledges
    irq_src = 15'h0010;
    bus_wr = 1'b1; bus_wdata = 32'h8000_0010;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b0; irq_src = '0;
    check("R7 persistent", 32'hC000_C010, 1'b1);
    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'h0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule